// File: doc/BRIEF.md
# Single-Cycle Modular Adder/Subtractor

This block returns the sum or the difference of two residues modulo N in one registered clock. X and Y must already lie in 0..N-1, and N must have its top bit set. A select input picks the operation. The block forms the plain sum or difference first. From that value it builds two candidates in parallel: one with N added and one with N taken away. The final value comes from a four-way pick that is steered by two sign bits, so no compare-and-fix loop is needed.

It is used as the add/subtract functional unit next to modular multipliers in a prime-field arithmetic datapath. A new operation can be issued on every clock. The result register holds its last value until the next valid request arrives.

Top module: `modq_addsub`

## Requirements
- R1: With op_sub_i = 0 and a valid request, res_o equals (x_i + y_i) mod mod_i on the cycle after the request.
- R2: With op_sub_i = 1 and a valid request, res_o equals (x_i - y_i) mod mod_i, which always lies in 0..mod_i-1, on the cycle after the request.
- R3: Sums up to 2*mod_i-2 that exceed the W-bit range are reduced correctly, with no wrap-around. For example, x_i = y_i = mod_i-1 gives mod_i-2.
- R4: An addition where x_i + y_i equals mod_i exactly gives 0.
- R5: A subtraction with x_i equal to y_i gives 0.
- R6: With x_i = 0 and y_i = mod_i-1, subtraction gives 1 and addition gives mod_i-1.
- R7: valid_o is valid_i delayed by exactly one clock. Back-to-back requests on consecutive clocks each produce their own result on consecutive clocks.
- R8: While valid_i is low, res_o keeps its previous value whatever x_i, y_i, mod_i and op_sub_i do, and valid_o stays low.
- R9: While rst_ni is low, and after its release, res_o is 0 and valid_o is 0 until the first valid request.
- R10: The operation encoding is op_sub_i = 0 for addition and op_sub_i = 1 for subtraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| op_sub_i | input | 1 | 0 = add, 1 = subtract |
| x_i | input | W | First operand, below mod_i |
| y_i | input | W | Second operand, below mod_i |
| mod_i | input | W | Modulus, top bit set |
| res_o | output | W | Registered result |
| valid_o | output | 1 | Result strobe, one clock after valid_i |

## Verification
The bench sweeps every legal modulus of a 5-bit configuration with every operand pair and both operations, issuing one request per clock. This stream covers several boundaries:
- Sums that land exactly on N: a design that compares with "greater than" instead of "not less than" returns N instead of 0.
- Sums that overflow W bits: too narrow an internal width returns a wrapped value.
- Equal operands on subtract: this exposes a wrong choice of sign bit, which would give N instead of 0.
- The case X = 0 with Y = N-1: this shows whether the add-N path is taken when the raw difference is negative.

An idle stretch with changing inputs exposes a result register that loads without a request.

// File: rtl/modq_pkg.sv
package modq_pkg;
  // select = {raw sign, down-candidate sign}
  typedef enum logic [1:0] {
    SEL_DN  = 2'b00,
    SEL_RAW = 2'b01,
    SEL_BAD = 2'b10,
    SEL_UP  = 2'b11
  } pick_e;
endpackage

// File: rtl/modq_raw.sv
module modq_raw #(
  parameter int IW = 10
) (
  input  logic [IW-1:0] a_i,
  input  logic [IW-1:0] b_i,
  input  logic          sub_i,
  output logic [IW-1:0] raw_o
);
  logic [IW-1:0] b_op;
  // subtract as a + ~b + 1 through one carry chain
  assign b_op  = sub_i ? ~b_i : b_i;
  assign raw_o = a_i + b_op + IW'(sub_i);
endmodule

// File: rtl/modq_fold.sv
module modq_fold #(
  parameter int IW = 10
) (
  input  logic [IW-1:0] raw_i,
  input  logic [IW-1:0] mod_i,
  output logic [IW-1:0] up_o,
  output logic [IW-1:0] dn_o
);
  assign up_o = raw_i + mod_i;
  assign dn_o = raw_i - mod_i;
endmodule

// File: rtl/modq_pick.sv
module modq_pick
  import modq_pkg::*;
#(
  parameter int IW = 10
) (
  input  logic [IW-1:0] raw_i,
  input  logic [IW-1:0] up_i,
  input  logic [IW-1:0] dn_i,
  output pick_e         sel_o,
  output logic [IW-1:0] res_o
);
  assign sel_o = pick_e'({raw_i[IW-1], dn_i[IW-1]});

  always_comb begin
    unique case (sel_o)
      SEL_DN:  res_o = dn_i;
      SEL_RAW: res_o = raw_i;
      SEL_BAD: res_o = up_i;
      SEL_UP:  res_o = up_i;
      default: res_o = raw_i;
    endcase
  end
endmodule

// File: rtl/modq_addsub.sv
module modq_addsub
  import modq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         op_sub_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] res_o,
  output logic         valid_o
);
  localparam int IW = W + 2;

  logic [IW-1:0] x_ext, y_ext, m_ext, raw, up, dn, picked;
  pick_e         sel;

  assign x_ext = {2'b00, x_i};
  assign y_ext = {2'b00, y_i};
  assign m_ext = {2'b00, mod_i};

  modq_raw #(.IW(IW)) u_raw (
    .a_i(x_ext), .b_i(y_ext), .sub_i(op_sub_i), .raw_o(raw)
  );

  modq_fold #(.IW(IW)) u_fold (
    .raw_i(raw), .mod_i(m_ext), .up_o(up), .dn_o(dn)
  );

  modq_pick #(.IW(IW)) u_pick (
    .raw_i(raw), .up_i(up), .dn_i(dn), .sel_o(sel), .res_o(picked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= picked[W-1:0];
    end
  end

  // legal operand condition
  logic legal;
  assign legal = (x_i < mod_i) && (y_i < mod_i) && mod_i[W-1];

  p_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));
  p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal) |=> (res_o < $past(mod_i)));
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal) |-> (picked[IW-1:W] == 2'b00));
  p_add_nonneg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal && !op_sub_i) |-> !raw[IW-1]);
  p_sel_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal) |-> (sel != SEL_BAD));
  p_equal_sub_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal && op_sub_i && (x_i == y_i)) |=> (res_o == '0));
endmodule

// File: tb/modq_addsub_bench.sv
`timescale 1ns/1ps
module modq_addsub_bench;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic         op_sub = 1'b0;
  logic [W-1:0] x = '0, y = '0, m = '0;
  logic [W-1:0] res;
  logic         vout;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modq_addsub #(.W(W)) u_modq_addsub (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_sub_i(op_sub),
    .x_i(x), .y_i(y), .mod_i(m), .res_o(res), .valid_o(vout)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(int xx, int yy, int nn, bit s);
    if (s && xx == yy)                 return "R5";
    if (xx == 0 && yy == nn - 1)       return "R6";
    if (!s && xx + yy == nn)           return "R4";
    if (!s && xx + yy >= (1 << W))     return "R3";
    if (s)                             return "R2/R10";
    return "R1/R10";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int    pend_exp;
    string pend_tag;
    bit    pend;
    logic [W-1:0] held;
    pend = 0;
    pend_exp = 0;

    // R9: reset state, during and after reset
    repeat (2) @(negedge clk);
    chk("R9", int'(res), 0);
    chk("R9", int'(vout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", int'(res), 0);
    chk("R9", int'(vout), 0);

    // exhaustive back-to-back stream (R1..R7, R10)
    for (int nn = (1 << (W-1)); nn < (1 << W); nn++) begin
      for (int s = 0; s < 2; s++) begin
        for (int xx = 0; xx < nn; xx++) begin
          for (int yy = 0; yy < nn; yy++) begin
            valid  = 1'b1;
            op_sub = s[0];
            x = W'(xx); y = W'(yy); m = W'(nn);
            @(negedge clk);
            if (pend) chk("R7", int'(vout), 1);
            pend_exp = s ? (xx + nn - yy) % nn : (xx + yy) % nn;
            pend_tag = tag_of(xx, yy, nn, s[0]);
            chk(pend_tag, int'(res), pend_exp);
            pend = 1;
          end
        end
      end
    end

    // R8: idle cycles with changing inputs
    held  = res;
    valid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      x = W'(k); y = W'(k + 3); m = W'(16 + k); op_sub = k[0];
      @(negedge clk);
      chk("R8", int'(res), int'(held));
      chk("R8", int'(vout), 0);
    end

    // R7: single request then idle
    valid = 1'b1; op_sub = 1'b0; x = 5'd20; y = 5'd19; m = 5'd29;
    @(negedge clk);
    valid = 1'b0;
    chk("R7", int'(vout), 1);
    chk("R3", int'(res), 10);
    @(negedge clk);
    chk("R7", int'(vout), 0);
    chk("R8", int'(res), 10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule